// File: doc/BRIEF.md
# Nesting Priority Interrupt Router

This block collects a bank of level-sensitive peripheral request lines and delivers them either to the main CPU or to a coprocessor. Each vector has a 3-bit priority and a destination bit. Software reaches these settings through a group-select register and an eight-slot data window. Level 0 turns a vector off.

On the CPU side, a maskable request is offered only while the I mask is clear. It must also have a level strictly above the active level. When the CPU acknowledges, the active level is saved on a level stack and replaced by the level of the accepted request. This lets up to seven maskable services nest. A return-from-interrupt pulse restores the saved level. A separate X request is offered whenever the X mask is clear, and it takes precedence over maskable requests. On the coprocessor side, the winning coprocessor-bound request is presented with its channel number. The request must exceed a programmable threshold.

A small state machine drives the CPU handshake. In state ST_IDLE nothing is offered. The transition idle_to_offer fires when an eligible request exists. In state ST_OFFER the request and vector address are shown and are re-evaluated each cycle. The transition offer_to_idle fires on acknowledge or when no eligible request remains. The transition offer_hold stays in ST_OFFER and refreshes the winner.

Top module: `irq_router`

## Requirements
- R1: After reset, the vector base reads 0xFF, every vector is at level 0 with CPU target, the coprocessor threshold is 0, the active level is 0, and cpu_req and cop_req are low.
- R2: Register map on reg_addr: 0 is the vector base (8 bits), 1 is the group select, 2 is the coprocessor threshold (3 bits), and 8 to 15 are the window slots for vectors group*8+slot. A slot holds the target in bit 7 (1 = coprocessor) and the level in bits 2:0, and bits 6:3 read back as 0. Reads are combinational and writes take effect at the clock edge.
- R3: A vector at level 0 is never offered to the CPU or the coprocessor.
- R4: A CPU-target vector is offered only while cpu_imask is low and its level is strictly greater than cpu_level. A request at a level equal to cpu_level is blocked.
- R5: Among eligible requests the highest level wins, and among equal levels the highest vector index wins.
- R6: cpu_vec_addr is the base in bits 15:8 and twice the vector index in bits 7:0.
- R7: An acknowledge while cpu_req is high pushes cpu_level onto the level stack and loads the offered level into cpu_level. cpu_req is low in the following cycle. Nested preemptions stack in this way.
- R8: cpu_rti without an accepted acknowledge in the same cycle pops the stack into cpu_level. A pop on an empty stack gives level 0.
- R9: With xirq_in high and cpu_xmask low, the CPU is offered vector address base:0xF4 regardless of cpu_imask. Acknowledging it pushes the level and sets cpu_level to 7. Nothing is offered while the eight-entry stack is full.
- R10: A coprocessor-target vector with level above the threshold drives cop_req with its index on cop_chan, and it never raises cpu_req.
- R11: cpu_req, cpu_vec_addr, cop_req and cop_chan are registered and reflect their inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_in | input | NUM_VEC | Peripheral request lines |
| xirq_in | input | 1 | X-maskable request |
| cpu_imask | input | 1 | CPU I mask bit |
| cpu_xmask | input | 1 | CPU X mask bit |
| cpu_ack | input | 1 | CPU accepts the offered request |
| cpu_rti | input | 1 | Return-from-interrupt pulse |
| cpu_req | output | 1 | Request to the CPU |
| cpu_vec_addr | output | 16 | Vector address of the offered request |
| cpu_level | output | 3 | Active priority level |
| cop_req | output | 1 | Request to the coprocessor |
| cop_chan | output | VIDX_W | Coprocessor channel (vector index) |

## Verification
The bench builds three nested preemptions (3, 4, 5, then 7) and unwinds them with return pulses, including one pop past the bottom of the stack. A router that pushed the wrong value or failed to restore it would report a wrong cpu_level during the unwind. An equal-level request is held while a level-3 service runs; a `>=` compare in place of `>` would raise cpu_req there. Ties between two level-3 vectors, a disabled vector, a below-threshold coprocessor vector and a coprocessor-target vector each catch a router that picked the low index, forwarded a level-0 vector, or leaked coprocessor traffic to the CPU. The X request under a set I mask and a relocated base check the address formation.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_TOP = 3'd7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } hs_state_t;

    typedef struct packed {
        logic             to_cop;
        logic [LVL_W-1:0] lvl;
    } vec_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int NUM_VEC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [3:0]           addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic [7:0]           base,
    output logic [LVL_W-1:0]     cop_thr,
    output vec_cfg_t             cfg [NUM_VEC]
);
    localparam int NGRP  = NUM_VEC / 8;
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic [GRP_W-1:0] grp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= 8'hFF;
            grp     <= '0;
            cop_thr <= '0;
        end else if (we) begin
            case (addr)
                4'd0:    base    <= wdata;
                4'd1:    grp     <= wdata[GRP_W-1:0];
                4'd2:    cop_thr <= wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar s = 0; s < 8; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg[g*8+s] <= '0;
                end else if (we && addr == 4'(8 + s) && grp == GRP_W'(g)) begin
                    cfg[g*8+s].to_cop <= wdata[7];
                    cfg[g*8+s].lvl    <= wdata[LVL_W-1:0];
                end
            end
        end
    end

    always_comb begin
        vec_cfg_t sel;
        sel   = cfg[{grp, addr[2:0]}];
        rdata = '0;
        case (addr)
            4'd0:    rdata = base;
            4'd1:    rdata = 8'(grp);
            4'd2:    rdata = 8'(cop_thr);
            default: begin
                if (addr[3]) rdata = {sel.to_cop, 4'b0, sel.lvl};
            end
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_VEC = 16,
    localparam int VIDX_W = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] elig,
    input  vec_cfg_t           cfg [NUM_VEC],
    output logic               found,
    output logic [VIDX_W-1:0]  win_idx,
    output logic [LVL_W-1:0]   win_lvl
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (elig[i] && (!found || cfg[i].lvl >= win_lvl)) begin
                found   = 1'b1;
                win_idx = VIDX_W'(i);
                win_lvl = cfg[i].lvl;
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] din,
    output logic [LVL_W-1:0] top,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && cnt != CNT_W'(DEPTH)) begin
            mem[cnt[$clog2(DEPTH)-1:0]] <= din;
            cnt <= cnt + 1'b1;
        end else if (pop && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign full = (cnt == CNT_W'(DEPTH));
    assign top  = (cnt == '0) ? '0 : mem[$clog2(DEPTH)'(cnt - 1'b1)];

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> cnt < CNT_W'(DEPTH));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_pkg::*;
#(
    parameter int NUM_VEC = 16,
    parameter int DEPTH   = 8,
    parameter logic [7:0] XVEC_LO = 8'hF4,
    localparam int VIDX_W = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic               xirq_in,
    input  logic               cpu_imask,
    input  logic               cpu_xmask,
    input  logic               cpu_ack,
    input  logic               cpu_rti,
    output logic               cpu_req,
    output logic [15:0]        cpu_vec_addr,
    output logic [LVL_W-1:0]   cpu_level,
    output logic               cop_req,
    output logic [VIDX_W-1:0]  cop_chan
);
    logic [7:0]       base;
    logic [LVL_W-1:0] cop_thr;
    vec_cfg_t         cfg [NUM_VEC];

    irq_cfg_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .base(base),
        .cop_thr(cop_thr), .cfg(cfg)
    );

    logic [LVL_W-1:0] cur_lvl;
    logic [NUM_VEC-1:0] cpu_elig, cop_elig;

    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) begin
            cpu_elig[i] = irq_in[i] && cfg[i].lvl != '0 && !cfg[i].to_cop
                          && !cpu_imask && cfg[i].lvl > cur_lvl;
            cop_elig[i] = irq_in[i] && cfg[i].lvl != '0 && cfg[i].to_cop
                          && cfg[i].lvl > cop_thr;
        end
    end

    logic              cpu_found, cop_found;
    logic [VIDX_W-1:0] cpu_idx, cop_idx;
    logic [LVL_W-1:0]  cpu_wlvl, cop_wlvl;

    irq_arbiter #(.NUM_VEC(NUM_VEC)) u_cpu_arb (
        .elig(cpu_elig), .cfg(cfg), .found(cpu_found),
        .win_idx(cpu_idx), .win_lvl(cpu_wlvl)
    );

    irq_arbiter #(.NUM_VEC(NUM_VEC)) u_cop_arb (
        .elig(cop_elig), .cfg(cfg), .found(cop_found),
        .win_idx(cop_idx), .win_lvl(cop_wlvl)
    );

    logic             stk_push, stk_pop, stk_full;
    logic [LVL_W-1:0] stk_top;

    irq_level_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
        .din(cur_lvl), .top(stk_top), .full(stk_full)
    );

    hs_state_t         state, state_nx;
    logic              off_x;
    logic [VIDX_W-1:0] off_idx;
    logic [LVL_W-1:0]  off_lvl;
    logic              x_ok, want, accept;
    logic              cop_req_q;
    logic [VIDX_W-1:0] cop_chan_q;
    logic [LVL_W-1:0]  cop_lvl_q;

    assign x_ok   = xirq_in && !cpu_xmask;
    assign want   = (x_ok || cpu_found) && !stk_full;
    assign accept = (state == ST_OFFER) && cpu_ack;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (want) state_nx = ST_OFFER;
            ST_OFFER: begin
                if (cpu_ack)    state_nx = ST_IDLE;
                else if (!want) state_nx = ST_IDLE;
                else            state_nx = ST_OFFER;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign stk_push = accept;
    assign stk_pop  = cpu_rti && !accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            off_x      <= 1'b0;
            off_idx    <= '0;
            off_lvl    <= '0;
            cur_lvl    <= '0;
            cop_req_q  <= 1'b0;
            cop_chan_q <= '0;
            cop_lvl_q  <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_OFFER) begin
                off_x   <= x_ok;
                off_idx <= cpu_idx;
                off_lvl <= x_ok ? LVL_TOP : cpu_wlvl;
            end
            if (accept)       cur_lvl <= off_lvl;
            else if (cpu_rti) cur_lvl <= stk_top;
            cop_req_q  <= cop_found;
            cop_chan_q <= cop_idx;
            cop_lvl_q  <= cop_wlvl;
        end
    end

    always_comb begin
        cpu_req      = (state == ST_OFFER);
        cpu_vec_addr = {base, off_x ? XVEC_LO : 8'({off_idx, 1'b0})};
        cpu_level    = cur_lvl;
        cop_req      = cop_req_q;
        cop_chan     = cop_chan_q;
    end

    // R4
    above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !off_x |-> off_lvl > cur_lvl);

    // R4
    imask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_req) && !off_x |-> !$past(cpu_imask));

    // R3
    no_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !off_x |-> cfg[off_idx].lvl != '0);

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ack |=> !cpu_req);

    // R8
    rti_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rti && !(cpu_req && cpu_ack) |=> cpu_level <= $past(cpu_level));

    // R10
    cop_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_req |-> cop_lvl_q > $past(cop_thr));
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] irq_in = '0;
    logic        xirq_in = 1'b0;
    logic        cpu_imask = 1'b0;
    logic        cpu_xmask = 1'b1;
    logic        cpu_ack = 1'b0;
    logic        cpu_rti = 1'b0;
    logic        cpu_req;
    logic [15:0] cpu_vec_addr;
    logic [2:0]  cpu_level;
    logic        cop_req;
    logic [3:0]  cop_chan;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .xirq_in(xirq_in), .cpu_imask(cpu_imask), .cpu_xmask(cpu_xmask),
        .cpu_ack(cpu_ack), .cpu_rti(cpu_rti), .cpu_req(cpu_req),
        .cpu_vec_addr(cpu_vec_addr), .cpu_level(cpu_level),
        .cop_req(cop_req), .cop_chan(cop_chan)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_ack;
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic pulse_rti;
        cpu_rti = 1'b1;
        @(negedge clk);
        cpu_rti = 1'b0;
    endtask

    // {imask, irq[15:0], exp_req, exp_lo[7:0], exp_cop, exp_chan[3:0]}
    localparam logic [30:0] TBL [11] = '{
        {1'b0, 16'h0002, 1'b1, 8'h02, 1'b0, 4'h0},  // R4 single level-3
        {1'b0, 16'h0006, 1'b1, 8'h04, 1'b0, 4'h0},  // R5 tie -> high index
        {1'b0, 16'h000E, 1'b1, 8'h06, 1'b0, 4'h0},  // R5 higher level wins
        {1'b0, 16'h0010, 1'b0, 8'h00, 1'b0, 4'h0},  // R3 disabled
        {1'b0, 16'h0020, 1'b0, 8'h00, 1'b1, 4'h5},  // R10 cop only
        {1'b0, 16'h0040, 1'b0, 8'h00, 1'b0, 4'h0},  // R10 below threshold
        {1'b0, 16'h0226, 1'b1, 8'h12, 1'b1, 4'h5},  // R6 level 7 vector
        {1'b1, 16'h040E, 1'b0, 8'h00, 1'b0, 4'h0},  // R4 imask set
        {1'b0, 16'h1000, 1'b0, 8'h00, 1'b0, 4'h0},  // R3 disabled cop vector
        {1'b0, 16'h0460, 1'b1, 8'h14, 1'b1, 4'h5},  // R11 mixed
        {1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, 4'h0}   // R11 drop
    };

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cpu_req", 16'(cpu_req), 16'h0);
        chk("R1 cop_req", 16'(cop_req), 16'h0);
        chk("R1 level", 16'(cpu_level), 16'h0);
        rd(4'd0, d); chk("R1 base", 16'(d), 16'h00FF);
        rd(4'd9, d); chk("R1 slot cfg", 16'(d), 16'h0);

        // configuration
        wr(4'd1, 8'd0);
        wr(4'd9, 8'h03); wr(4'd10, 8'h03); wr(4'd11, 8'h05);
        wr(4'd12, 8'h00); wr(4'd13, 8'h86); wr(4'd14, 8'h82);
        wr(4'd1, 8'd1);
        wr(4'd9, 8'h07); wr(4'd10, 8'h04); wr(4'd12, 8'h80);
        wr(4'd15, 8'h7B);
        wr(4'd2, 8'd3);
        // R2 readback
        rd(4'd15, d); chk("R2 unused bits zero", 16'(d), 16'h0003);
        rd(4'd9, d);  chk("R2 group1 slot1", 16'(d), 16'h0007);
        rd(4'd2, d);  chk("R2 threshold", 16'(d), 16'h0003);
        wr(4'd1, 8'd0);
        rd(4'd13, d); chk("R2 group0 slot5", 16'(d), 16'h0086);
        cpu_xmask = 1'b1;

        // table walk (R3 R4 R5 R6 R10 R11)
        for (int k = 0; k < 11; k++) begin
            cpu_imask = TBL[k][30];
            irq_in    = TBL[k][29:14];
            @(negedge clk);
            chk($sformatf("R4/R5 tbl%0d cpu_req", k), 16'(cpu_req), 16'(TBL[k][13]));
            if (TBL[k][13])
                chk($sformatf("R6 tbl%0d addr", k), cpu_vec_addr, {8'hFF, TBL[k][12:5]});
            chk($sformatf("R10 tbl%0d cop_req", k), 16'(cop_req), 16'(TBL[k][4]));
            if (TBL[k][4])
                chk($sformatf("R10 tbl%0d chan", k), 16'(cop_chan), 16'(TBL[k][3:0]));
        end
        cpu_imask = 1'b0;

        // R7 nesting: 3 -> 4 -> 5 -> 7
        irq_in = 16'h0002;
        @(negedge clk);
        chk("R7 offer v1", cpu_vec_addr, 16'hFF02);
        pulse_ack;
        chk("R7 level 3", 16'(cpu_level), 16'h3);
        chk("R7 req drops", 16'(cpu_req), 16'h0);
        irq_in = 16'h0006;
        repeat (2) @(negedge clk);
        chk("R4 equal level blocked", 16'(cpu_req), 16'h0);
        irq_in = 16'h0406;
        @(negedge clk);
        chk("R7 preempt v10", cpu_vec_addr, 16'hFF14);
        pulse_ack;
        chk("R7 level 4", 16'(cpu_level), 16'h4);
        irq_in = 16'h040E;
        repeat (2) @(negedge clk);
        chk("R7 preempt v3", cpu_vec_addr, 16'hFF06);
        pulse_ack;
        chk("R7 level 5", 16'(cpu_level), 16'h5);
        irq_in = 16'h060E;
        repeat (2) @(negedge clk);
        chk("R7 preempt v9", cpu_vec_addr, 16'hFF12);
        pulse_ack;
        chk("R7 level 7", 16'(cpu_level), 16'h7);
        @(negedge clk);
        chk("R4 nothing above 7", 16'(cpu_req), 16'h0);
        irq_in = 16'h0000;
        @(negedge clk);
        // R8 unwind
        pulse_rti; chk("R8 pop to 5", 16'(cpu_level), 16'h5);
        pulse_rti; chk("R8 pop to 4", 16'(cpu_level), 16'h4);
        pulse_rti; chk("R8 pop to 3", 16'(cpu_level), 16'h3);
        pulse_rti; chk("R8 pop to 0", 16'(cpu_level), 16'h0);
        pulse_rti; chk("R8 empty pop", 16'(cpu_level), 16'h0);

        // R9 X request
        xirq_in = 1'b1; cpu_xmask = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 xmask holds", 16'(cpu_req), 16'h0);
        cpu_xmask = 1'b0; cpu_imask = 1'b1;
        @(negedge clk);
        chk("R9 x offered", 16'(cpu_req), 16'h1);
        chk("R9 x addr", cpu_vec_addr, 16'hFFF4);
        cpu_xmask = 1'b1;
        pulse_ack;
        chk("R9 x level", 16'(cpu_level), 16'h7);
        xirq_in = 1'b0;
        pulse_rti;
        chk("R9 x return", 16'(cpu_level), 16'h0);
        cpu_imask = 1'b0;

        // R6 relocated base
        wr(4'd0, 8'h3A);
        irq_in = 16'h0008;
        @(negedge clk);
        chk("R6 relocated addr", cpu_vec_addr, 16'h3A06);
        irq_in = 16'h0000;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule